// File: doc/BRIEF.md
# Injected Conversion Trigger Controller

This block decides the clock cycle in which an injected-group conversion begins. Software can request a start by writing a start bit. Hardware can request one through an edge on one of sixteen asynchronous event lines. A 4-bit select code picks the line, and a 2-bit mode picks which edges count. Each line passes through a two-flop synchronizer. The selected level is compared with its value one cycle earlier. A qualifying edge, or a pending software bit, produces a one-cycle start pulse toward the converter core.

All triggers are qualified by the converter-enable flag and by the core's busy indication. A trigger that is refused is dropped, not held for later. The software bit can be read back. It clears itself in the cycle the start pulse is raised. Every pin is a plain control level or a pulse. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `inj_trig_ctrl`

## Requirements
- R1: A start-bit write (`sw_start_wr` high for a cycle) made while `conv_en` is 0 leaves `sw_start_bit` at 0, and a start bit never yields a pulse while `conv_en` is 0.
- R2: A start-bit write with `conv_en` at 1 makes `sw_start_bit` read 1 from the next cycle. The bit reads 0 from the cycle in which `start_pulse` is high. A write in the same cycle as that clearing wins, and the bit stays 1. Both outputs are 0 after reset.
- R3: `edge_mode` encodes 00 = no external triggering, 01 = rising edges, 10 = falling edges, 11 = both edge directions.
- R4: `evt_sel` = k makes `evt_in[k]` the only line that can trigger. Edges on every other line have no effect on `start_pulse`.
- R5: Each event line crosses two flip-flops. A level change present at clock edge k gives an accepted trigger as `start_pulse` high in the cycle after edge k+2.
- R6: The cycle in which `evt_sel` or `edge_mode` takes a new value produces no external trigger, even if the newly selected line differs in level from the old one.
- R7: `start_pulse` is high for exactly one cycle. A trigger arising in the cycle where the pulse is high is dropped.
- R8: A trigger arising while `core_busy` is 1 is dropped and is not raised later. A pending start bit stays pending until the core is idle.
- R9: External edges are ignored while `conv_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_en | input | 1 | Converter enable flag |
| sw_start_wr | input | 1 | One-cycle write that sets the software start bit |
| edge_mode | input | 2 | Edge selection: 00 off, 01 rising, 10 falling, 11 both |
| evt_sel | input | 4 | Index of the trigger event line |
| evt_in | input | 16 | Asynchronous external event lines |
| core_busy | input | 1 | Converter core is converting |
| start_pulse | output | 1 | One-cycle conversion start |
| sw_start_bit | output | 1 | Readable state of the software start bit |

## Verification
A stale edge-history or configuration register would appear at `start_pulse` as a spurious or missing pulse. It would show within three cycles of the select or mode change that exposes it. A wrong synchronizer depth shifts every externally triggered pulse by at least one cycle. A wrong set or clear of the start bit shows on `sw_start_bit` in the cycle after the write or the pulse. A reference model compares both outputs on every cycle, so any of these faults is caught in the first cycle where it differs.

// File: rtl/inj_trig_pkg.sv
package inj_trig_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_mode_e;
endpackage

// File: rtl/evt_sync.sv
module evt_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= async_in;

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
  end

  assign sync_out = stg[STAGES-1];

  logic live_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live_q <= 1'b0;
    else        live_q <= 1'b1;

  assert_sync_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> stg[0] == $past(async_in));
endmodule

// File: rtl/edge_detect.sv
module edge_detect
  import inj_trig_pkg::*;
#(
  parameter int N_EVT = 16,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] lvl_vec,
  input  logic [SEL_W-1:0] sel,
  input  logic [1:0]       mode,
  output logic             hit
);
  logic             cur_lvl, hist_q, cfg_chg;
  logic [SEL_W-1:0] sel_q;
  logic [1:0]       mode_q;
  logic             rise, fall;

  assign cur_lvl = lvl_vec[sel];
  assign cfg_chg = (sel != sel_q) || (mode != mode_q);
  assign rise    = cur_lvl & ~hist_q;
  assign fall    = ~cur_lvl & hist_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hist_q <= 1'b0;
      sel_q  <= '0;
      mode_q <= EDGE_OFF;
    end else begin
      hist_q <= cur_lvl;
      sel_q  <= sel;
      mode_q <= mode;
    end

  always_comb begin
    unique case (edge_mode_e'(mode))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    if (cfg_chg) hit = 1'b0;
  end

  assert_off_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == EDGE_OFF) |-> !hit);
endmodule

// File: rtl/start_ctl.sv
module start_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic conv_en,
  input  logic sw_wr,
  input  logic ext_hit,
  input  logic core_busy,
  output logic start_pulse,
  output logic sw_bit
);
  logic start_q, sw_q, fire;

  assign fire = conv_en && !core_busy && !start_q && (ext_hit || sw_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      start_q <= 1'b0;
      sw_q    <= 1'b0;
    end else begin
      start_q <= fire;
      if (sw_wr && conv_en) sw_q <= 1'b1;
      else if (fire)        sw_q <= 1'b0;
    end

  assign start_pulse = start_q;
  assign sw_bit      = sw_q;

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);
  assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    core_busy |=> !start_q);
  assert_disabled_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_en |=> !start_q);
  assert_write_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && !conv_en && !sw_q) |=> !sw_q);
  assert_bit_cleared_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(start_q) && !$past(sw_wr && conv_en)) |-> !sw_q);
endmodule

// File: rtl/inj_trig_ctrl.sv
module inj_trig_ctrl #(
  parameter int N_EVT       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W = $clog2(N_EVT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             conv_en,
  input  logic             sw_start_wr,
  input  logic [1:0]       edge_mode,
  input  logic [SEL_W-1:0] evt_sel,
  input  logic [N_EVT-1:0] evt_in,
  input  logic             core_busy,
  output logic             start_pulse,
  output logic             sw_start_bit
);
  logic [N_EVT-1:0] evt_lvl;
  logic             ext_hit;

  evt_sync #(.WIDTH(N_EVT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(evt_in), .sync_out(evt_lvl)
  );

  edge_detect #(.N_EVT(N_EVT)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl_vec(evt_lvl), .sel(evt_sel),
    .mode(edge_mode), .hit(ext_hit)
  );

  start_ctl u_start (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .sw_wr(sw_start_wr),
    .ext_hit(ext_hit), .core_busy(core_busy),
    .start_pulse(start_pulse), .sw_bit(sw_start_bit)
  );
endmodule

// File: tb/inj_trig_ctrl_tb.sv
module inj_trig_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_en = 1'b0;
  logic        sw_start_wr = 1'b0;
  logic [1:0]  edge_mode = 2'b00;
  logic [3:0]  evt_sel = 4'd0;
  logic [15:0] evt_in = 16'h0;
  logic        core_busy = 1'b0;
  logic        start_pulse, sw_start_bit;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 1'b0;
  string tag = "R2";

  always #(CLK_PERIOD/2) clk = ~clk;

  inj_trig_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .conv_en(conv_en), .sw_start_wr(sw_start_wr),
    .edge_mode(edge_mode), .evt_sel(evt_sel), .evt_in(evt_in),
    .core_busy(core_busy), .start_pulse(start_pulse), .sw_start_bit(sw_start_bit)
  );

  // Reference model: history of sampled event words, last configuration,
  // expected outputs.
  logic [15:0] hq[$];
  int          last_sel, last_mode;
  bit          exp_start, exp_bit;

  always @(posedge clk) begin
    if (!rst_n) begin
      hq = '{16'h0, 16'h0, 16'h0};
      last_sel = 0; last_mode = 0;
      exp_start = 0; exp_bit = 0;
    end else begin
      bit cur, old, chg, ext, fire;
      cur = hq[1][evt_sel];
      old = hq[2][evt_sel];
      chg = (int'(evt_sel) != last_sel) || (int'(edge_mode) != last_mode);
      ext = 0;
      if (!chg)
        case (edge_mode)
          2'b01: ext = cur && !old;
          2'b10: ext = !cur && old;
          2'b11: ext = cur != old;
          default: ext = 0;
        endcase
      fire = conv_en && !core_busy && !exp_start && (ext || exp_bit);
      exp_start = fire;
      if (sw_start_wr && conv_en) exp_bit = 1;
      else if (fire) exp_bit = 0;
      hq.push_front(evt_in);
      void'(hq.pop_back());
      last_sel = evt_sel; last_mode = edge_mode;
    end
  end

  always @(negedge clk) begin
    if (!done && rst_n) begin
      n_chk++;
      if (start_pulse !== exp_start || sw_start_bit !== exp_bit) begin
        n_fail++;
        $display("FAIL %s cycle %0d: start=%b bit=%b expected start=%b bit=%b",
                 tag, cyc, start_pulse, sw_start_bit, exp_start, exp_bit);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: expected completion, got timeout");
      finish_run();
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sw_write();
    sw_start_wr = 1'b1; step(1); sw_start_wr = 1'b0;
  endtask

  task automatic toggle(int line);
    evt_in[line] = ~evt_in[line]; step(5);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    tag = "R2"; step(3);                     // reset state
    tag = "R1"; sw_write(); step(4);         // write with enable off
    conv_en = 1'b1;
    tag = "R2"; sw_write(); step(4);         // software start
    core_busy = 1'b1; sw_write(); step(3);   // pending while busy
    core_busy = 1'b0; step(3);
    tag = "R3"; evt_sel = 4'd5; edge_mode = 2'b01; step(3);
    toggle(5); toggle(5);                    // rise then fall
    edge_mode = 2'b10; step(3); toggle(5); toggle(5);
    edge_mode = 2'b11; step(3); toggle(5); toggle(5);
    edge_mode = 2'b00; step(3); toggle(5); toggle(5);
    tag = "R4"; edge_mode = 2'b11; step(3);
    for (int i = 0; i < 16; i++) if (i != 5) toggle(i);
    evt_sel = 4'd15; step(3); toggle(15); toggle(15);
    evt_sel = 4'd0;  step(3); toggle(0);
    tag = "R5"; evt_sel = 4'd9; step(3);
    evt_in[9] = ~evt_in[9]; step(1);
    for (int i = 0; i < 4; i++) step(1);
    tag = "R6"; evt_in = 16'h0; step(4);
    evt_in[3] = 1'b1; evt_sel = 4'd9; step(5);
    evt_sel = 4'd3; step(5);                 // levels differ, no trigger
    edge_mode = 2'b01; step(5);
    evt_in[3] = 1'b0; edge_mode = 2'b10; step(5);
    tag = "R7"; edge_mode = 2'b11; step(3);
    evt_in[3] = 1'b1; step(1); evt_in[3] = 1'b0; step(6);
    sw_write(); evt_in[3] = 1'b1; step(6);
    tag = "R8"; core_busy = 1'b1; evt_in[3] = 1'b0; step(6);
    core_busy = 1'b0; step(4);
    tag = "R9"; conv_en = 1'b0; toggle(3); toggle(3);
    sw_write(); step(3);
    conv_en = 1'b1; step(4);
    tag = "R1"; sw_write(); conv_en = 1'b0; step(4); conv_en = 1'b1; step(4);
    tag = "R2"; sw_write(); sw_write(); step(5);
    finish_run();
  end
endmodule